// File: doc/BRIEF.md
# Two-Phase Full-Bridge Pulse Generator

This block drives the two diagonal switch pairs of a full-bridge converter. The bridge feeds an isolation transformer. One full switching period is split into two equal halves. Drive output A pulses in the first half and drive output B pulses in the second half, so the transformer primary sees alternating polarity. Both pulses take their length from one width command, counted on an 8-bit timebase.

A controller writes a width command and a period command through a small write port. Each command has its own enable. Written values wait in holding registers and are copied into the active set only on the last clock of a period, so a period in progress is never cut short or stretched. The width is limited to 240 counts when it is written. The period command sets the length of each half, which lets the controller change the switching frequency. A one-clock strobe marks the first count of every period so the controller can line up its sampling.

Top module: `hbridge_pwm`

## Requirements
- R1: While reset is low, both drive outputs are low. The first clock after reset is released is the first count of a period. That period uses width 0 and a half length of 256 counts.
- R2: A written width above 240 is stored as 240. Written values 0 to 240 are stored unchanged.
- R3: drive_a is high for the first min(W, L) counts of the first half of each period and low for the rest of the period. W is the active width and L is the half length.
- R4: drive_b is high for the first min(W, L) counts of the second half of each period and low for the rest of the period.
- R5: drive_a and drive_b are never high together. With an active width of 0 both stay low for the whole period.
- R6: frame_start is high for exactly one clock, on the first count of every period. Periods are 2·L clocks long.
- R7: A write changes nothing in the period during which it occurs. It takes effect from the next period start. The width enable and the period enable act independently, so a register that is not written keeps its value.
- R8: A period command P (0 to 255) gives a half length of L = P + 1 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_width_en | input | 1 | Writes wr_width into the width holding register |
| wr_width | input | 8 | Pulse width command in counts |
| wr_period_en | input | 1 | Writes wr_period into the period holding register |
| wr_period | input | 8 | Half-length command; each half lasts wr_period+1 counts |
| drive_a | output | 1 | Drive for the first diagonal pair (first half) |
| drive_b | output | 1 | Drive for the second diagonal pair (second half) |
| frame_start | output | 1 | One-clock strobe on the first count of each period |

## Verification
The assertions assume the write port is sampled only on clock edges. They also assume reset is applied once, from time zero, so that the active registers start from their defaults. Nothing is assumed about how often the controller writes, because each write lands in a holding register. The bench drives the write inputs just after a falling edge and holds them for exactly one rising edge. It places every write on the first count of a period, so the rest of that period shows whether the write leaked through early. The bench sweeps short half lengths with every width from zero to just past the half length. At the full 256-count half length it steps widths across the 240 clamp.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

  // Bridge half currently being timed
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } half_e;

  // Limit a command to an upper bound
  function automatic int unsigned clamp_cmd(input int unsigned cmd, input int unsigned lim);
    return (cmd > lim) ? lim : cmd;
  endfunction

  // Pulse is on while the position inside a half is below the width
  function automatic logic in_pulse(input int unsigned pos, input int unsigned width);
    return pos < width;
  endfunction

  // Number of counts in one half for a given period command
  function automatic int unsigned half_len(input int unsigned cmd);
    return cmd + 1;
  endfunction

endpackage

// File: rtl/hbpwm_regs.sv
module hbpwm_regs
  import hbpwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_WIDTH = 240,
  parameter int unsigned DEF_CMD   = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_width_en,
  input  logic [CNT_W-1:0] wr_width,
  input  logic             wr_period_en,
  input  logic [CNT_W-1:0] wr_period,
  input  logic             load,
  output logic [CNT_W-1:0] width_hold,
  output logic [CNT_W-1:0] period_hold,
  output logic [CNT_W-1:0] width_act,
  output logic [CNT_W-1:0] period_act
);

  localparam logic [CNT_W-1:0] DEF_PERIOD = CNT_W'(DEF_CMD);

  logic [CNT_W-1:0] width_in;

  // Clamp on entry so every stored width is already legal
  always_comb begin
    width_in = CNT_W'(clamp_cmd(32'(wr_width), MAX_WIDTH));
  end

  // Holding registers: written any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_hold  <= '0;
      period_hold <= DEF_PERIOD;
    end else begin
      if (wr_width_en)  width_hold  <= width_in;
      if (wr_period_en) period_hold <= wr_period;
    end
  end

  // Active registers: copied only on the last clock of a period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_act  <= '0;
      period_act <= DEF_PERIOD;
    end else if (load) begin
      width_act  <= width_hold;
      period_act <= period_hold;
    end
  end

endmodule

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase
  import hbpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_act,
  output logic [CNT_W-1:0] cnt,
  output half_e            phase,
  output logic             half_end,
  output logic             frame_end,
  output logic             frame_first
);

  always_comb begin
    half_end    = (cnt == period_act);
    frame_end   = half_end && (phase == PH_B);
    frame_first = (cnt == '0) && (phase == PH_A);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_A;
    end else if (half_end) begin
      cnt   <= '0;
      phase <= (phase == PH_A) ? PH_B : PH_A;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hbpwm_drive.sv
module hbpwm_drive
  import hbpwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned N_PHASES = 2
) (
  input  half_e               phase,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    width_act,
  output logic [N_PHASES-1:0] drive
);

  logic pulse_on;

  always_comb begin
    pulse_on = in_pulse(32'(cnt), 32'(width_act));
  end

  // One output per half; only the output owning the current half may pulse
  for (genvar g = 0; g < N_PHASES; g++) begin : g_phase
    assign drive[g] = (phase == half_e'(1'(g))) && pulse_on;
  end

endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
  import hbpwm_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned MAX_WIDTH     = 240,
  parameter int unsigned DEF_PHASE_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_width_en,
  input  logic [CNT_W-1:0] wr_width,
  input  logic             wr_period_en,
  input  logic [CNT_W-1:0] wr_period,
  output logic             drive_a,
  output logic             drive_b,
  output logic             frame_start
);

  localparam int unsigned DEF_CMD  = DEF_PHASE_LEN - 1;
  localparam int unsigned N_PHASES = 2;

  // Named internal events
  logic [CNT_W-1:0]    width_hold;
  logic [CNT_W-1:0]    period_hold;
  logic [CNT_W-1:0]    width_act;
  logic [CNT_W-1:0]    period_act;
  logic [CNT_W-1:0]    cnt;
  half_e               phase;
  logic                half_end;
  logic                frame_end;
  logic                frame_first;
  logic [N_PHASES-1:0] drive;

  hbpwm_regs #(
    .CNT_W    (CNT_W),
    .MAX_WIDTH(MAX_WIDTH),
    .DEF_CMD  (DEF_CMD)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_width_en (wr_width_en),
    .wr_width    (wr_width),
    .wr_period_en(wr_period_en),
    .wr_period   (wr_period),
    .load        (frame_end),
    .width_hold  (width_hold),
    .period_hold (period_hold),
    .width_act   (width_act),
    .period_act  (period_act)
  );

  hbpwm_timebase #(
    .CNT_W(CNT_W)
  ) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_act (period_act),
    .cnt        (cnt),
    .phase      (phase),
    .half_end   (half_end),
    .frame_end  (frame_end),
    .frame_first(frame_first)
  );

  hbpwm_drive #(
    .CNT_W   (CNT_W),
    .N_PHASES(N_PHASES)
  ) u_drv (
    .phase    (phase),
    .cnt      (cnt),
    .width_act(width_act),
    .drive    (drive)
  );

  assign drive_a     = drive[0];
  assign drive_b     = drive[1];
  assign frame_start = frame_first;

endmodule

// File: rtl/hbpwm_chk.sv
module hbpwm_chk #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_WIDTH = 240
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drive_a,
  input logic             drive_b,
  input logic             frame_start,
  input logic             frame_end,
  input logic [CNT_W-1:0] width_hold,
  input logic [CNT_W-1:0] width_act,
  input logic [CNT_W-1:0] period_act
);

  localparam logic [CNT_W-1:0] MAX_W = CNT_W'(MAX_WIDTH);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (!drive_a && !drive_b)
        else $error("drive active during reset");
    end
  end

  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    width_hold <= MAX_W);

  assert_a_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_a) |-> frame_start);

  assert_b_not_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_b |-> !frame_start);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_a && drive_b));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (width_act == '0) |-> (!drive_a && !drive_b));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_end_then_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_start);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(width_act) && $stable(period_act)));

endmodule

bind hbridge_pwm hbpwm_chk #(
  .CNT_W    (CNT_W),
  .MAX_WIDTH(MAX_WIDTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .drive_a    (drive_a),
  .drive_b    (drive_b),
  .frame_start(frame_start),
  .frame_end  (frame_end),
  .width_hold (width_hold),
  .width_act  (width_act),
  .period_act (period_act)
);

// File: tb/sim_hbridge_pwm.sv
`timescale 1ns/1ps
module sim_hbridge_pwm;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_width_en = 1'b0;
  logic [7:0] wr_width = '0;
  logic       wr_period_en = 1'b0;
  logic [7:0] wr_period = '0;
  logic       drive_a;
  logic       drive_b;
  logic       frame_start;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int cw;
  int cl;

  always #10 clk = ~clk;

  hbridge_pwm u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_width_en (wr_width_en),
    .wr_width    (wr_width),
    .wr_period_en(wr_period_en),
    .wr_period   (wr_period),
    .drive_a     (drive_a),
    .drive_b     (drive_b),
    .frame_start (frame_start)
  );

  function automatic int clampv(input int w);
    return (w > 240) ? 240 : w;
  endfunction

  // Walk one period starting at its first count (sampled just after a falling
  // edge). Optional writes are issued on the first count and must not affect
  // the period being checked.
  task automatic check_frame(input int w, input int l,
                             input bit we_w, input int nw,
                             input bit we_p, input int np,
                             input string ctx);
    int eff;
    bit fa, fb, fo, ff;
    logic ea, eb, ef;
    eff = (w < l) ? w : l;
    fa = 0; fb = 0; fo = 0; ff = 0;
    for (int i = 0; i < 2 * l; i++) begin
      ea = (i < l) && (i < eff);
      eb = (i >= l) && ((i - l) < eff);
      ef = (i == 0);
      if (drive_a !== ea && !fa) begin
        fa = 1;
        $display("FAIL R3 [%s] W=%0d L=%0d idx=%0d drive_a=%b expected %b", ctx, w, l, i, drive_a, ea);
      end
      if (drive_b !== eb && !fb) begin
        fb = 1;
        $display("FAIL R4 [%s] W=%0d L=%0d idx=%0d drive_b=%b expected %b", ctx, w, l, i, drive_b, eb);
      end
      if ((drive_a === 1'b1) && (drive_b === 1'b1) && !fo) begin
        fo = 1;
        $display("FAIL R5 [%s] idx=%0d both drives high, expected at most one", ctx, i);
      end
      if (frame_start !== ef && !ff) begin
        ff = 1;
        $display("FAIL R6 [%s] W=%0d L=%0d idx=%0d frame_start=%b expected %b", ctx, w, l, i, frame_start, ef);
      end
      if (i == 0) begin
        wr_width_en  = we_w;
        wr_width     = 8'(nw);
        wr_period_en = we_p;
        wr_period    = 8'(np);
      end else if (i == 1) begin
        wr_width_en  = 1'b0;
        wr_period_en = 1'b0;
      end
      @(negedge clk); #1;
    end
    wr_width_en  = 1'b0;
    wr_period_en = 1'b0;
    total += 4;
    bad   += int'(fa) + int'(fb) + int'(fo) + int'(ff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: drives low while reset is held
    total++;
    if (drive_a !== 1'b0 || drive_b !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: drive_a=%b drive_b=%b expected 0 0", drive_a, drive_b);
    end
    rst_n = 1'b1;

    // R1 default period (W=0, L=256); R7 width-only write
    cw = 0; cl = 256;
    check_frame(cw, cl, 1, 200, 0, 0, "R1 default frame");
    cw = 200;
    check_frame(cw, cl, 0, 0, 0, 0, "R7 width only");

    // R8 sweep of short halves with every width up to just past L
    foreach (sweep_p[k]) begin
      for (int w = 0; w <= sweep_p[k] + 2; w++) begin
        check_frame(cw, cl, 1, w, 1, sweep_p[k], "R8 period sweep");
        cw = clampv(w);
        cl = sweep_p[k] + 1;
      end
    end

    // R2 clamp at full half length
    foreach (clamp_w[k]) begin
      check_frame(cw, cl, 1, clamp_w[k], 1, 255, "R2 clamp");
      cw = clampv(clamp_w[k]);
      cl = 256;
    end

    // R7 period-only write, then a width wider than the half
    check_frame(cw, cl, 0, 0, 1, 99, "R7 period only");
    cl = 100;
    check_frame(cw, cl, 1, 255, 0, 0, "R2 clamp wide");
    cw = 240;
    check_frame(cw, cl, 0, 0, 0, 0, "R7 final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int sweep_p [6] = '{0, 1, 2, 3, 6, 11};
  int clamp_w [7] = '{255, 241, 240, 239, 1, 0, 250};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule